// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter

This block is the transmit half of a half-duplex serial channel in which one shared clock line carries both directions. Software-side logic pushes bytes through a byte write port into a two-entry transmit buffer. A single-bit status flag tells the writer whether at least one entry is free. The oldest buffered byte is loaded into the serializer and sent least significant bit first, one bit per shift clock period. The data line changes only on falling clock edges, so a receiver can sample on rising edges.

The channel runs as master or as slave. As master, the block drives the shift clock from a programmable divider of the system clock. The clock rests high between bytes. A byte starts only after the far end pulls the ready line low. As slave, the block follows an external shift clock and drives the ready line low for as long as it holds data to send. Clock and ready pins switch direction according to mode and enable. Transmission counts as active only while transmit is enabled and receive is not. Dropping the enable empties the buffer and aborts any shifting.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset with transmit disabled, `sdo_o` and `sclk_o` are 1, both output enables are 0, and `buf_space_o` is 1.
- R2: The buffer holds two bytes, and two back-to-back writes to an empty buffer are both accepted. `buf_space_o` is 1 while at least one entry is free and 0 when both are occupied. A write made while both entries are occupied is discarded, even in the cycle an entry is being freed.
- R3: Bytes leave in write order, least significant bit first, eight bits each. A byte keeps its entry until its last bit has been shifted. A write accepted while another byte is shifting is sent afterwards.
- R4: While `tx_en_i` is 0 the buffer is empty, no shifting takes place, and writes are discarded. Clearing `tx_en_i` empties a buffer that holds bytes.
- R5: While `rx_en_i` is 1, transmission is inactive regardless of `tx_en_i`. This covers buffer clearing, discarded writes and pin enables.
- R6: `sclk_oe_o` is 1 exactly when transmission is active in master mode (`master_i`=1). `rdy_oe_o` is 1 exactly when transmission is active in slave mode.
- R7: In master mode, `sclk_o` rests at 1 between bytes. A byte starts only while `rdy_i` is 0, after a two-flop synchronizer. `sdo_o` changes only together with a falling edge of `sclk_o`.
- R8: In master mode, each low and each high phase of `sclk_o` lasts `div_i`+1 system clock cycles.
- R9: In slave mode, `rdy_o` is 0 while the buffer holds a byte and 1 otherwise. Bits advance on falling edges of `sclk_i`, which is synchronized by two flops. A byte completes at the eighth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to buffer |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable; blocks transmission when 1 |
| master_i | input | 1 | 1 = master (drives clock), 0 = slave (drives ready) |
| div_i | input | 8 | Half-period of master clock minus one, in system cycles |
| buf_space_o | output | 1 | 1 while the buffer has a free entry |
| sdo_o | output | 1 | Serial data out |
| sclk_i | input | 1 | Shift clock from pin (slave) |
| sclk_o | output | 1 | Shift clock to pin (master) |
| sclk_oe_o | output | 1 | Shift clock pin output enable |
| rdy_i | input | 1 | Ready from pin (master), active low |
| rdy_o | output | 1 | Ready to pin (slave), active low |
| rdy_oe_o | output | 1 | Ready pin output enable |

## Verification
The master path is driven in several ways:
- Directed byte pairs held back by a high ready line tell buffering apart from immediate start.
- A pair of writes followed by a third shows the discard of writes to a full buffer.
- Random write bursts at random divider settings, compared against a bench occupancy model, expose ordering, bit order and flag timing errors, including writes that land in the cycle an entry frees.

Measured low-phase lengths at two divider values separate a correct half-period from an off-by-one. Disabling with bytes pending, and enabling while receive is on, show whether stale data leaks out. Slave transfers clocked by the bench confirm ready behaviour and falling-edge data updates.

// File: rtl/sync_ser_tx_pkg.sv
package sync_ser_tx_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } sclk_ev_t;
endpackage

// File: rtl/ssx_tx_buf.sv
module ssx_tx_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic              do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= data_i;
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  p_drop_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  p_flush_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/ssx_pin_sync.sv
module ssx_pin_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= {STAGES{RST_VAL}};
    else         sh <= {sh[STAGES-2:0], d_i};
  end

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/ssx_clk_gen.sv
module ssx_clk_gen
  import sync_ser_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             busy_i,
  input  logic             start_ok_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output sclk_ev_t         ev_o
);
  logic [DIV_W-1:0] hcnt;
  logic             sclk_q, at_lim;

  assign at_lim  = (hcnt >= div_i);
  assign ev_o.fall = run_i & sclk_q & at_lim & (busy_i | start_ok_i);
  assign ev_o.rise = run_i & ~sclk_q & at_lim;
  assign sclk_o  = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      hcnt   <= '0;
    end else if (!run_i) begin
      sclk_q <= 1'b1;
      hcnt   <= '0;
    end else if (ev_o.fall || ev_o.rise) begin
      sclk_q <= ~sclk_q;
      hcnt   <= '0;
    end else if (!at_lim) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sclk_q);
  p_low_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !sclk_q && !at_lim) |=> (!sclk_q || !run_i));
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
  import sync_ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  sclk_ev_t          ev_i,
  input  logic              has_data_i,
  input  logic [DATA_W-1:0] head_i,
  output logic              busy_o,
  output logic              pop_o,
  output logic              sdo_o
);
  localparam int BW = $clog2(DATA_W);

  logic [BW-1:0] idx;
  logic          busy_q, sdo_q, last;

  assign last   = (idx == BW'(DATA_W - 1));
  assign pop_o  = active_i & busy_q & ev_i.rise & last;
  assign busy_o = busy_q;
  assign sdo_o  = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx    <= '0;
      sdo_q  <= 1'b1;
    end else if (!active_i) begin
      busy_q <= 1'b0;
      idx    <= '0;
      sdo_q  <= 1'b1;
    end else begin
      // data moves only on falling clock edges
      if (ev_i.fall && (busy_q || has_data_i)) begin
        sdo_q  <= head_i[idx];
        busy_q <= 1'b1;
      end
      if (ev_i.rise && busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  p_entry_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> has_data_i);
  p_sdo_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !ev_i.fall && $past(active_i)) |=> $stable(sdo_q));
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sync_ser_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              master_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              buf_space_o,
  output logic              sdo_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              rdy_i,
  output logic              rdy_o,
  output logic              rdy_oe_o
);
  logic              active, run_m, empty, full, busy, pop;
  logic              rdy_s, sclk_s, sclk_prev;
  logic [DATA_W-1:0] head;
  sclk_ev_t          gen_ev, pin_ev, ev;

  // receive enable wins over transmit enable (shared clock line)
  assign active = tx_en_i & ~rx_en_i;
  assign run_m  = active & master_i;

  ssx_tx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .flush_i (~active),
    .push_i  (wr_en_i & active),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  ssx_pin_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rdy_sync (
    .clk_i, .rst_ni, .d_i(rdy_i), .q_o(rdy_s)
  );
  ssx_pin_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev <= 1'b1;
    else         sclk_prev <= sclk_s;
  end

  assign pin_ev.fall = active & ~master_i & sclk_prev & ~sclk_s;
  assign pin_ev.rise = active & ~master_i & ~sclk_prev & sclk_s;

  ssx_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk_i, .rst_ni,
    .run_i      (run_m),
    .busy_i     (busy),
    .start_ok_i (~empty & ~rdy_s),
    .div_i,
    .sclk_o,
    .ev_o       (gen_ev)
  );

  assign ev = master_i ? gen_ev : pin_ev;

  ssx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .active_i   (active),
    .ev_i       (ev),
    .has_data_i (~empty),
    .head_i     (head),
    .busy_o     (busy),
    .pop_o      (pop),
    .sdo_o
  );

  assign buf_space_o = ~full;
  assign sclk_oe_o   = run_m;
  assign rdy_oe_o    = active & ~master_i;
  assign rdy_o       = empty;

  p_rx_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i |=> (empty || !rx_en_i));
  p_pin_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sclk_oe_o, rdy_oe_o}));
  p_slave_rdy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_oe_o && busy) |-> !rdy_o);
endmodule

// File: tb/sync_ser_tx_tb.sv
module sync_ser_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 0, tx_en_i = 0, rx_en_i = 0, master_i = 1;
  logic [7:0] wr_data_i = 0, div_i = 8'd1;
  logic       sclk_i = 1, rdy_i = 1;
  logic       buf_space_o, sdo_o, sclk_o, sclk_oe_o, rdy_o, rdy_oe_o;

  int checks = 0, errors = 0, cyc = 0;
  int nfall = 0, fall_t = 0, low_len = 0, bitc = 0, model_cnt = 0;
  bit mon_on = 0, model_act = 0;
  logic [7:0] acc;
  logic [7:0] exp_q[$], rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  sync_ser_tx u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .tx_en_i, .rx_en_i,
    .master_i, .div_i, .buf_space_o, .sdo_o, .sclk_i, .sclk_o,
    .sclk_oe_o, .rdy_i, .rdy_o, .rdy_oe_o
  );

  always @(negedge sclk_o) begin nfall++; fall_t = cyc; end
  always @(posedge sclk_o) begin
    low_len = cyc - fall_t;
    if (mon_on) begin
      acc[bitc] = sdo_o;
      bitc++;
      if (bitc == 8) begin rx_q.push_back(acc); bitc = 0; model_cnt--; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    chk(buf_space_o == (model_cnt < 2), "R2", "space flag before write",
        buf_space_o, model_cnt < 2);
    if (model_act && model_cnt < 2) begin exp_q.push_back(b); model_cnt++; end
    wr_en_i = 1; wr_data_i = b;
  endtask

  task automatic wr_off();
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_cmp(input string req);
    for (int i = 0; i < 20000 && (model_cnt != 0); i++) @(negedge clk);
    idle(4);
    chk(rx_q.size() == exp_q.size(), req, "byte count", rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], req, "byte value", rx_q[i], exp_q[i]);
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic slave_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_i = 0; idle(8);
      sclk_i = 1; b[i] = sdo_o; idle(8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int f0;
    void'($urandom(32'h5eed_1234));
    idle(3); rst_ni = 1; idle(2);
    // R1 reset state
    chk(sdo_o == 1 && sclk_o == 1, "R1", "sdo/sclk idle", {sdo_o, sclk_o}, 3);
    chk(!sclk_oe_o && !rdy_oe_o, "R1", "oe low", {sclk_oe_o, rdy_oe_o}, 0);
    chk(buf_space_o == 1, "R1", "space", buf_space_o, 1);

    // R6 master direction
    tx_en_i = 1; model_act = 1; mon_on = 1; idle(1);
    chk(sclk_oe_o == 1 && rdy_oe_o == 0, "R6", "master oe", {sclk_oe_o, rdy_oe_o}, 2);

    // R7 hold while ready high, R2 full / discard
    f0 = nfall;
    wr(8'hA5); wr(8'h3C); wr(8'hFF); wr_off();
    chk(buf_space_o == 0, "R2", "full flag", buf_space_o, 0);
    idle(40);
    chk(nfall == f0 && sclk_o == 1, "R7", "no start while ready high", nfall - f0, 0);
    rdy_i = 0;
    drain_cmp("R3");
    chk(low_len == 2, "R8", "low phase div=1", low_len, 2);
    chk(buf_space_o == 1 && sclk_o == 1, "R7", "idle high after bytes", {buf_space_o, sclk_o}, 3);

    // R8 other divider
    div_i = 8'd5; wr(8'h96); wr_off(); drain_cmp("R8");
    chk(low_len == 6, "R8", "low phase div=5", low_len, 6);
    div_i = 8'd1;

    // R3 write while shifting
    wr(8'h81); wr_off();
    for (int i = 0; i < 100 && nfall == f0; i++) @(negedge clk);
    idle(3); wr(8'h7E); wr_off(); drain_cmp("R3");

    // R4 disable flushes
    rdy_i = 1; idle(3);
    wr(8'h11); wr(8'h22); wr_off();
    chk(buf_space_o == 0, "R4", "full before disable", buf_space_o, 0);
    tx_en_i = 0; model_act = 0; model_cnt = 0; exp_q.delete(); idle(2);
    chk(buf_space_o == 1 && sclk_oe_o == 0, "R4", "flushed", {buf_space_o, sclk_oe_o}, 2);
    wr(8'h33); wr_off();
    tx_en_i = 1; model_act = 1; rdy_i = 0; f0 = nfall; idle(60);
    chk(nfall == f0, "R4", "nothing sent after flush", nfall - f0, 0);

    // R5 receive enable blocks
    rx_en_i = 1; model_act = 0; idle(1);
    chk(!sclk_oe_o && !rdy_oe_o, "R5", "oe off", {sclk_oe_o, rdy_oe_o}, 0);
    wr(8'h44); wr_off();
    rx_en_i = 0; model_act = 1; idle(60);
    chk(nfall == f0 && buf_space_o == 1, "R5", "write ignored", nfall - f0, 0);

    // random bursts
    for (int r = 0; r < 8; r++) begin
      div_i = 8'($urandom % 4);
      for (int k = 0; k < 30; k++) begin
        if ($urandom % 3 == 0) begin wr(8'($urandom)); wr_off(); end
        else idle(1);
      end
      drain_cmp("R3");
    end

    // slave mode
    tx_en_i = 0; model_act = 0; idle(2);
    master_i = 0; mon_on = 0; tx_en_i = 1; model_act = 1; idle(2);
    chk(rdy_oe_o == 1 && sclk_oe_o == 0, "R6", "slave oe", {sclk_oe_o, rdy_oe_o}, 1);
    chk(rdy_o == 1, "R9", "ready high when empty", rdy_o, 1);
    wr(8'hC6); wr(8'h5A); wr_off(); idle(2);
    chk(rdy_o == 0, "R9", "ready low with data", rdy_o, 0);
    slave_byte(b); chk(b == 8'hC6, "R9", "slave byte 0", b, 8'hC6);
    model_cnt--; idle(4);
    chk(rdy_o == 0 && buf_space_o == 1, "R9", "second byte pending", {rdy_o, buf_space_o}, 1);
    slave_byte(b); chk(b == 8'h5A, "R9", "slave byte 1", b, 8'h5A);
    model_cnt--; idle(4);
    chk(rdy_o == 1, "R9", "ready high after drain", rdy_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule